// File: doc/BRIEF.md
# Shared Mailbox Bank with Interrupt Aggregation

This block holds a small bank of single-word message slots that several processors share. A sending processor posts a word with the top bit set, and that bit marks the slot occupied. The receiving processor reads the word and then writes zero to hand the slot back. Each slot drives two level-sensitive conditions, "slot holds a message" and "slot is free". An aggregation stage combines these conditions into one or more interrupt lines. Each line has its own enable mask.

All access goes through a plain 32-bit register bus with one-cycle read latency. Slot `i` has a data word at byte address `0x10*i`. With the local-enable variant built in, it also has a local occupied-interrupt enable at `0x10*i + 0x4` and a local free-interrupt enable at `0x10*i + 0x8`, both in bit 0. Line `n` has an enable mask at `0x100 + 4*n`. The raw condition register is at `0x304`. A read-only resource-count register is at `0x380`. Software uses the count register to learn how many slots and lines the instance has. The number of slots (up to eight) and the number of lines are parameters. The semaphore and doorbell counts are parameters that only appear in the count register.

Top module: `mbx_hub`

## Requirements
- R1: After reset every slot word reads 0, every local enable and every line mask reads 0, the condition register reads 0x0000_000F for four slots, and all interrupt lines are low.
- R2: Writing a slot data word with bit 31 set stores the whole word. The slot then reads back that word, and its occupied condition is set.
- R3: Writing a slot data word with bit 31 clear stores it and leaves the slot free. Writing 0x0 returns every bit of the slot to zero.
- R4: In the condition register at 0x304, bit i is set when slot i is free (bit 31 clear), and bit 8+i is set when slot i is occupied. Bits for absent slots and all bits above 15 read as 0.
- R5: Writes to the condition register change no slot and no mask.
- R6: The line mask at 0x100+4*n uses the condition register's bit layout. It stores only the bits of existing slots and reads back with all other bits zero.
- R7: Interrupt line n is high in every cycle in which some condition bit is set, enabled in the mask of line n, and enabled by the matching local enable. Otherwise it is low. The line follows state one cycle after the write that changes it and holds while the condition persists.
- R8: The local occupied enable (slot offset 0x4, bit 0) gates bit 8+i and the local free enable (slot offset 0x8, bit 0) gates bit i for every line. Both read back in bit 0.
- R9: The count register at 0x380 reads slots in [3:0], shared semaphores in [7:4], arbitrated semaphores in [11:8], doorbells in [15:12], lines in [19:16], and zero above.
- R10: Unmapped addresses (slot offset 0xC, slots or lines beyond the configured count, other pages) read 0, and writes to them change nothing.
- R11: Read data appears in the cycle after a read strobe and is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| rd_en | input | 1 | Read strobe; data returns next cycle |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| irq | output | NUM_LINES | Level-sensitive aggregated interrupt lines |

## Verification
The assertions check several properties on every cycle. A data write with the top bit set must leave the slot occupied, and a zero write must free it. A condition-register write must leave slots and masks untouched. A line with an all-zero mask must never be high. Idle read data must be zero, and the count register must always return its configured value. Only the bench scenarios can show full correctness of the aggregation: for every combination of slot occupancy, line mask and local enable, each line must match the AND-OR expected from the requirements. The bench scenarios also cover exact read-back encodings, the zero reads from absent resources, and that the interrupt level holds across idle cycles.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W     = 12;
    localparam int WORD_W     = 32;
    localparam int FULL_BIT   = WORD_W - 1;
    localparam int MAX_SLOTS  = 8;
    localparam int STAT_W     = 2 * MAX_SLOTS;
    localparam int IDX_W      = $clog2(MAX_SLOTS);
    localparam int LINE_IDX_W = 4;

    localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'h304;
    localparam logic [ADDR_W-1:0] DIMS_ADDR   = 12'h380;
    localparam logic [3:0]        LINE_PAGE   = 4'h1;

    typedef enum logic [1:0] {
        SR_DATA     = 2'd0,
        SR_FULL_EN  = 2'd1,
        SR_EMPTY_EN = 2'd2,
        SR_NONE     = 2'd3
    } slot_reg_e;

    typedef struct packed {
        logic                  slot_hit;
        logic                  line_hit;
        logic                  stat_hit;
        logic                  dim_hit;
        logic [IDX_W-1:0]      slot_idx;
        logic [LINE_IDX_W-1:0] line_idx;
        slot_reg_e             sreg;
    } dec_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_LINES = 2,
    parameter bit LOCAL_EN  = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec      = '0;
        dec.sreg = SR_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr[ADDR_W-1:7] == '0 && int'(addr[6:4]) < NUM_SLOTS) begin
                dec.slot_idx = addr[6:4];
                case (addr[3:2])
                    2'd0: begin
                        dec.slot_hit = 1'b1;
                        dec.sreg     = SR_DATA;
                    end
                    2'd1: if (LOCAL_EN) begin
                        dec.slot_hit = 1'b1;
                        dec.sreg     = SR_FULL_EN;
                    end
                    2'd2: if (LOCAL_EN) begin
                        dec.slot_hit = 1'b1;
                        dec.sreg     = SR_EMPTY_EN;
                    end
                    default: ;
                endcase
            end
            if (addr[ADDR_W-1:8] == LINE_PAGE && addr[7:6] == 2'b00 &&
                int'(addr[5:2]) < NUM_LINES) begin
                dec.line_hit = 1'b1;
                dec.line_idx = addr[5:2];
            end
            dec.stat_hit = (addr == STATUS_ADDR);
            dec.dim_hit  = (addr == DIMS_ADDR);
        end
    end
endmodule

// File: rtl/mbx_slot_bank.sv
module mbx_slot_bank
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter bit LOCAL_EN  = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr,
    input  logic [IDX_W-1:0]                    idx,
    input  slot_reg_e                           sreg,
    input  logic [WORD_W-1:0]                   wdata,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]    word,
    output logic [NUM_SLOTS-1:0]                full,
    output logic [NUM_SLOTS-1:0]                fen,
    output logic [NUM_SLOTS-1:0]                een
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][WORD_W-1:0] word;
        logic [NUM_SLOTS-1:0]             fen;
        logic [NUM_SLOTS-1:0]             een;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (wr && int'(idx) == i) begin
                case (sreg)
                    SR_DATA:     st_d.word[i] = wdata;
                    SR_FULL_EN:  st_d.fen[i]  = wdata[0];
                    SR_EMPTY_EN: st_d.een[i]  = wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_full
        assign full[i] = st_q.word[i][FULL_BIT];
    end

    if (LOCAL_EN) begin : g_local
        assign fen = st_q.fen;
        assign een = st_q.een;
    end else begin : g_nolocal
        assign fen = '1;
        assign een = '1;
    end
endmodule

// File: rtl/mbx_irq_agg.sv
module mbx_irq_agg
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_LINES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr,
    input  logic [LINE_IDX_W-1:0]               line_idx,
    input  logic [STAT_W-1:0]                   wmask,
    input  logic [NUM_SLOTS-1:0]                full,
    input  logic [NUM_SLOTS-1:0]                fen,
    input  logic [NUM_SLOTS-1:0]                een,
    output logic [NUM_LINES-1:0][STAT_W-1:0]    line_en,
    output logic [STAT_W-1:0]                   status,
    output logic [NUM_LINES-1:0]                irq
);
    function automatic logic [STAT_W-1:0] valid_bits();
        logic [STAT_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            v[i]             = 1'b1;
            v[MAX_SLOTS + i] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [STAT_W-1:0] VALID_MASK = valid_bits();

    typedef struct packed {
        logic [NUM_LINES-1:0][STAT_W-1:0] en;
    } agg_t;

    agg_t              st_d, st_q;
    logic [STAT_W-1:0] loc_mask;

    always_comb begin
        status   = '0;
        loc_mask = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            status[i]               = ~full[i];
            status[MAX_SLOTS + i]   = full[i];
            loc_mask[i]             = een[i];
            loc_mask[MAX_SLOTS + i] = fen[i];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NUM_LINES; n++) begin
            if (wr && int'(line_idx) == n) st_d.en[n] = wmask & VALID_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_en = st_q.en;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign irq[n] = |(st_q.en[n] & status & loc_mask);
    end
endmodule

// File: rtl/mbx_hub.sv
module mbx_hub
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_LINES = 2,
    parameter int NUM_SSEM  = 0,
    parameter int NUM_ASEM  = 0,
    parameter int NUM_BELLS = 0,
    parameter bit LOCAL_EN  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    output logic [NUM_LINES-1:0]  irq
);
    localparam logic [WORD_W-1:0] DIMS_WORD = {12'b0, 4'(NUM_LINES), 4'(NUM_BELLS),
                                               4'(NUM_ASEM), 4'(NUM_SSEM), 4'(NUM_SLOTS)};

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } top_t;

    dec_t                             dec;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] word;
    logic [NUM_SLOTS-1:0]             full, fen, een;
    logic [NUM_LINES-1:0][STAT_W-1:0] line_en;
    logic [STAT_W-1:0]                status;
    top_t                             st_d, st_q;

    mbx_decode #(.NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES), .LOCAL_EN(LOCAL_EN)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    mbx_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .LOCAL_EN(LOCAL_EN)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_en && dec.slot_hit),
        .idx   (dec.slot_idx),
        .sreg  (dec.sreg),
        .wdata (wdata),
        .word  (word),
        .full  (full),
        .fen   (fen),
        .een   (een)
    );

    mbx_irq_agg #(.NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES)) u_agg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en && dec.line_hit),
        .line_idx (dec.line_idx),
        .wmask    (wdata[STAT_W-1:0]),
        .full     (full),
        .fen      (fen),
        .een      (een),
        .line_en  (line_en),
        .status   (status),
        .irq      (irq)
    );

    always_comb begin
        st_d.rdata = '0;
        if (rd_en) begin
            if (dec.slot_hit) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (int'(dec.slot_idx) == i) begin
                        case (dec.sreg)
                            SR_DATA:     st_d.rdata = word[i];
                            SR_FULL_EN:  st_d.rdata = {{(WORD_W-1){1'b0}}, fen[i]};
                            SR_EMPTY_EN: st_d.rdata = {{(WORD_W-1){1'b0}}, een[i]};
                            default: ;
                        endcase
                    end
                end
            end
            if (dec.line_hit) begin
                for (int n = 0; n < NUM_LINES; n++) begin
                    if (int'(dec.line_idx) == n) st_d.rdata = WORD_W'(line_en[n]);
                end
            end
            if (dec.stat_hit) st_d.rdata = WORD_W'(status);
            if (dec.dim_hit)  st_d.rdata = DIMS_WORD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/mbx_hub_chk.sv
module mbx_hub_chk
    import mbx_pkg::*;
#(
    parameter int                NUM_SLOTS = 4,
    parameter int                NUM_LINES = 2,
    parameter logic [WORD_W-1:0] DIMS_WORD = '0
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic                             rd_en,
    input logic [WORD_W-1:0]                wdata,
    input logic [WORD_W-1:0]                rdata,
    input logic [NUM_LINES-1:0]             irq,
    input dec_t                             dec,
    input logic [NUM_SLOTS-1:0]             full,
    input logic [NUM_LINES-1:0][STAT_W-1:0] line_en
);
    // R2
    slot_set_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.slot_hit && dec.sreg == SR_DATA && wdata[FULL_BIT])
        |=> full[$past(dec.slot_idx)]);

    // R3
    slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.slot_hit && dec.sreg == SR_DATA && wdata == '0)
        |=> !full[$past(dec.slot_idx)]);

    // R5
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.stat_hit) |=> ($stable(full) && $stable(line_en)));

    // R9
    dims_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.dim_hit) |=> (rdata == DIMS_WORD));

    // R11
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_chk
        // R7
        irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (line_en[n] == '0) |-> !irq[n]);
    end
endmodule

bind mbx_hub mbx_hub_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_LINES (NUM_LINES),
    .DIMS_WORD (DIMS_WORD)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .dec     (dec),
    .full    (full),
    .line_en (line_en)
);

// File: tb/tb_mbx_hub.sv
module tb_mbx_hub;
    localparam int NS = 4;
    localparam int NL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NL-1:0] irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m_word [NS];
    logic [NS-1:0] m_fen, m_een;
    logic [15:0] m_len [NL];

    always #4 clk = ~clk;

    mbx_hub #(.NUM_SLOTS(NS), .NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wr_slot(input int i, input logic [31:0] d);
        wr(12'(i * 16), d);
        m_word[i] = d;
    endtask

    task automatic wr_line(input int n, input logic [31:0] d);
        wr(12'h100 + 12'(4 * n), d);
        m_len[n] = d[15:0] & 16'h0F0F;
    endtask

    task automatic wr_loc(input int i, input logic f, input logic e);
        wr(12'(i * 16 + 4), {31'b0, f});
        wr(12'(i * 16 + 8), {31'b0, e});
        m_fen[i] = f;
        m_een[i] = e;
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < NS; i++) begin
            s[i]     = ~m_word[i][31];
            s[8 + i] = m_word[i][31];
        end
        return s;
    endfunction

    function automatic logic exp_irq(input int n);
        logic [15:0] lm;
        lm = '0;
        for (int i = 0; i < NS; i++) begin
            lm[i]     = m_een[i];
            lm[8 + i] = m_fen[i];
        end
        return |(m_len[n] & exp_status() & lm);
    endfunction

    task automatic check_irqs(input string req);
        for (int n = 0; n < NL; n++) check(req, {31'b0, irq[n]}, {31'b0, exp_irq(n)});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NS; i++) begin
            m_word[i] = '0;
        end
        m_fen = '0; m_een = '0;
        for (int n = 0; n < NL; n++) m_len[n] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < NS; i++) begin
            rd(12'(i * 16), v);     check("R1 slot word", v, 32'h0);
            rd(12'(i * 16 + 4), v); check("R1 local full enable", v, 32'h0);
            rd(12'(i * 16 + 8), v); check("R1 local empty enable", v, 32'h0);
        end
        for (int n = 0; n < NL; n++) begin
            rd(12'h100 + 12'(4 * n), v); check("R1 line mask", v, 32'h0);
        end
        rd(12'h304, v); check("R1 status", v, 32'h0000_000F);
        check("R1 irq", {30'b0, irq}, 32'h0);

        // R9 dimensioning: lines=2 in [19:16], slots=4 in [3:0]
        rd(12'h380, v); check("R9 dims", v, 32'h0002_0004);
        // R11 idle data is zero
        @(negedge clk); check("R11 idle rdata", rdata, 32'h0);

        // R2 / R3 / R4 per slot
        for (int i = 0; i < NS; i++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] d;
                d = 32'h8000_0000 | (32'h0135_79BD * (k + 1)) ^ 32'(i);
                wr_slot(i, d);
                rd(12'(i * 16), v); check("R2 full word readback", v, d);
                rd(12'h304, v);     check("R4 status after full", v, exp_status());
            end
            wr_slot(i, 32'h0000_1234 + 32'(i));
            rd(12'(i * 16), v); check("R3 payload without flag", v, 32'h0000_1234 + 32'(i));
            rd(12'h304, v);     check("R3 slot free", v, exp_status());
            wr_slot(i, 32'h8000_00FF);
            wr_slot(i, 32'h0);
            rd(12'(i * 16), v); check("R3 release clears word", v, 32'h0);
            rd(12'h304, v);     check("R4 status after release", v, exp_status());
        end

        // R5 status writes ignored
        wr_slot(1, 32'h8000_0001);
        wr(12'h304, 32'hFFFF_FFFF);
        rd(12'h304, v); check("R5 status unchanged", v, exp_status());
        rd(12'h010, v); check("R5 slot unchanged", v, 32'h8000_0001);
        rd(12'h100, v); check("R5 mask unchanged", v, 32'h0);

        // R10 unmapped addresses
        wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C, v); check("R10 slot offset C", v, 32'h0);
        wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, v); check("R10 absent slot", v, 32'h0);
        wr(12'h108, 32'hFFFF_FFFF); rd(12'h108, v); check("R10 absent line", v, 32'h0);
        wr(12'h200, 32'hFFFF_FFFF); rd(12'h200, v); check("R10 other page", v, 32'h0);
        rd(12'h304, v); check("R10 status untouched", v, exp_status());
        check("R10 irq untouched", {30'b0, irq}, 32'h0);

        // R6 mask readback keeps only existing slot bits
        wr_line(0, 32'hFFFF_FFFF);
        rd(12'h100, v); check("R6 mask readback", v, 32'h0000_0F0F);
        wr_line(1, 32'h0000_0A05);
        rd(12'h104, v); check("R6 mask readback line1", v, 32'h0000_0A05);
        check_irqs("R8 local enables off");

        // R8 local enable readback
        for (int i = 0; i < NS; i++) begin
            wr_loc(i, 1'b1, 1'b1);
            rd(12'(i * 16 + 4), v); check("R8 full enable readback", v, 32'h1);
            rd(12'(i * 16 + 8), v); check("R8 empty enable readback", v, 32'h1);
        end

        // R7 sweep: every occupancy x every mask
        for (int f = 0; f < 16; f++) begin
            for (int i = 0; i < NS; i++) wr_slot(i, f[i] ? (32'h8000_0000 | 32'(f)) : 32'h0);
            for (int m = 0; m < 256; m++) begin
                logic [31:0] e0;
                e0 = {20'b0, 4'(m >> 4), 4'b0, 4'(m)};
                wr_line(0, e0);
                wr_line(1, ~e0);
                check_irqs("R7 aggregation sweep");
            end
        end

        // R7 level held across idle cycles
        wr_slot(2, 32'h8000_0022);
        wr_line(0, 32'h0000_0400);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check("R7 level hold", {31'b0, irq[0]}, 32'h1);
        end
        wr_slot(2, 32'h0);
        check("R7 drops on release", {31'b0, irq[0]}, 32'h0);

        // R8 sweep: local enables gate the shared masks
        wr_line(0, 32'h0000_0F0F);
        wr_line(1, 32'h0000_0F00);
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < NS; i++)
                wr_slot(i, (i % 2 == p) ? 32'h8000_0000 : 32'h0);
            for (int lm = 0; lm < 256; lm++) begin
                for (int i = 0; i < NS; i++) wr_loc(i, lm[4 + i], lm[i]);
                check_irqs("R8 local gating sweep");
            end
        end

        finish_run();
    end
endmodule